// File: doc/BRIEF.md
# Tiled Texel Fetch Unit

This unit turns one texel coordinate pair into one 8-bit display colour. Textures sit in an external asynchronous pseudo-static RAM with a 16-bit data bus. They are packed as square tiles of 4x4 texels, and each texel is a 4-bit code, so one tile fills 64 bits, or four consecutive memory words. There is no way to read a single texel on its own. Every request therefore fetches the whole tile that holds it, using one four-word sequential burst. A page-mode burst costs much less than four separate random reads.

A request carries U, V and a texture base word address, and is accepted with a valid/ready handshake. The unit computes the tile's word address and holds it on the memory bus for a first-access wait. It then steps through the next three words, allowing a shorter wait for each one. The final word goes straight into code selection. The selected 4-bit code indexes a 16-entry palette, which is loaded through its own write port, and the resulting colour is returned with a valid/ready handshake. Only one request is in flight at a time.

Top module: `texel_tile_fetch`

## Requirements
- R1: After reset, reqReady is 1, rspValid is 0, memRd is 0, and all 16 palette entries read as 0.
- R2: The first burst word address is texBase + ((V>>2) * 2^(U_W-2) + (U>>2)) * 4, modulo 2^ADDR_W. Tiles are row-major, and texBase is sampled when the request is accepted.
- R3: memRd is high for the whole burst and low at all other times. The burst addresses are tile address +0, +1, +2, +3. The first address is held FIRST_WAIT cycles and each later one NEXT_WAIT cycles. memData is sampled in the last cycle of each hold.
- R4: Burst word k supplies tile bits [16k+15:16k]. The texel at (U[1:0], V[1:0]) uses code bits [4*(4*V[1:0]+U[1:0]) +: 4].
- R5: The response colour is the palette entry indexed by the code. A palette entry is written when palWe is 1, with address palIdx and value palData.
- R6: From accept until the response handshake, reqReady stays 0, so only one request is outstanding.
- R7: While rspValid is 1 and rspReady is 0, rspValid stays 1 and rspColor does not change.
- R8: rspValid rises exactly FIRST_WAIT + 3*NEXT_WAIT cycles after the accepting clock edge.
- R9: A palette write that lands on an edge before the last word is captured changes the colour of the request in flight.
- R10: reqReady returns to 1 in the cycle after the response handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Unit idle and able to accept a request |
| reqU | input | U_W | Horizontal texel coordinate |
| reqV | input | V_W | Vertical texel coordinate |
| texBase | input | ADDR_W | Texture base word address |
| rspValid | output | 1 | Colour available |
| rspReady | input | 1 | Consumer takes the colour |
| rspColor | output | COLOR_W | Returned colour |
| palWe | input | 1 | Palette write enable |
| palIdx | input | 4 | Palette entry to write |
| palData | input | COLOR_W | Palette write value |
| memAddr | output | ADDR_W | Memory word address |
| memRd | output | 1 | Memory read active |
| memData | input | 16 | Memory read data |

## Verification
Several properties are checked on every clock cycle. A response held back by the consumer keeps its colour. An accepted request blocks further accepts. The burst address only holds or advances by one. A response always follows a burst. Idle returns right after a response is taken.

The exact burst timing, the tile address arithmetic and the nibble chosen inside the tile can only be shown by the bench scenarios. So can the effect of a palette write in the middle of a fetch. The bench covers them with a cycle-level reference model and with expected colours derived from the memory contents.

// File: rtl/texel_fetch_pkg.sv
package texel_fetch_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BURST = 2'd1,
    ST_RESP  = 2'd2
  } fetchState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;     // latch request fields, clear word index
    logic captureWord; // current memory word is valid this cycle
    logic advanceWord; // step to next burst word
    logic finishTile;  // last word captured, register the colour
  } ctrlStrobe_t;
endpackage

// File: rtl/tf_ctrl.sv
module tf_ctrl
  import texel_fetch_pkg::*;
#(
  parameter int FIRST_WAIT = 7,
  parameter int NEXT_WAIT  = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        rspReady,
  input  logic        lastWord,
  output ctrlStrobe_t strobe,
  output logic        reqReady,
  output logic        rspValid,
  output logic        memRd
);
  localparam int MAX_WAIT = (FIRST_WAIT > NEXT_WAIT) ? FIRST_WAIT : NEXT_WAIT;
  localparam int WAIT_W   = $clog2(MAX_WAIT + 1);

  fetchState_t state;
  logic [WAIT_W-1:0] waitCnt;
  logic waitDone;

  assign waitDone = (waitCnt == WAIT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (reqValid) begin
          state   <= ST_BURST;
          waitCnt <= WAIT_W'(FIRST_WAIT);
        end
        ST_BURST: begin
          if (waitDone) begin
            if (lastWord) state <= ST_RESP;
            else          waitCnt <= WAIT_W'(NEXT_WAIT);
          end else begin
            waitCnt <= waitCnt - WAIT_W'(1);
          end
        end
        ST_RESP: if (rspReady) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign reqReady = (state == ST_IDLE);
  assign rspValid = (state == ST_RESP);
  assign memRd    = (state == ST_BURST);

  always_comb begin
    strobe.loadReq     = reqReady && reqValid;
    strobe.captureWord = memRd && waitDone;
    strobe.advanceWord = strobe.captureWord && !lastWord;
    strobe.finishTile  = strobe.captureWord && lastWord;
  end
endmodule

// File: rtl/tf_datapath.sv
module tf_datapath
  import texel_fetch_pkg::*;
#(
  parameter int U_W     = 8,
  parameter int V_W     = 8,
  parameter int ADDR_W  = 20,
  parameter int COLOR_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [U_W-1:0]     reqU,
  input  logic [V_W-1:0]     reqV,
  input  logic [ADDR_W-1:0]  texBase,
  input  logic               palWe,
  input  logic [3:0]         palIdx,
  input  logic [COLOR_W-1:0] palData,
  input  logic [15:0]        memData,
  output logic [ADDR_W-1:0]  memAddr,
  output logic               lastWord,
  output logic [COLOR_W-1:0] rspColor
);
  localparam int WORD_W    = 16;
  localparam int TILE_BITS = 64;
  localparam int WORDS     = TILE_BITS / WORD_W;
  localparam int IDX_W     = $clog2(WORDS);
  localparam int CODE_W    = 4;
  localparam int PAL_DEPTH = 1 << CODE_W;
  localparam int TILE_IDX_W = (U_W - 2) + (V_W - 2);

  logic [ADDR_W-1:0]     tileAddr;
  logic [IDX_W-1:0]      wordIdx;
  logic [3:0]            subIdx;
  logic [WORD_W-1:0]     tileBuf [WORDS-1];
  logic [TILE_BITS-1:0]  tileBits;
  logic [CODE_W-1:0]     code;
  logic [COLOR_W-1:0]    palMem [PAL_DEPTH];
  logic [COLOR_W-1:0]    colorReg;
  logic [TILE_IDX_W-1:0] tileIdx;

  // row-major tiles, power-of-two row length
  assign tileIdx = {reqV[V_W-1:2], reqU[U_W-1:2]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tileAddr <= '0;
      wordIdx  <= '0;
      subIdx   <= '0;
    end else if (strobe.loadReq) begin
      tileAddr <= texBase + ADDR_W'({tileIdx, 2'b00});
      wordIdx  <= '0;
      subIdx   <= {reqV[1:0], reqU[1:0]};
    end else if (strobe.advanceWord) begin
      wordIdx  <= wordIdx + IDX_W'(1);
    end
  end

  assign memAddr  = tileAddr + ADDR_W'(wordIdx);
  assign lastWord = (wordIdx == IDX_W'(WORDS - 1));

  generate
    for (genvar k = 0; k < WORDS - 1; k++) begin : g_word
      always_ff @(posedge clk) begin
        if (!rstN) tileBuf[k] <= '0;
        else if (strobe.captureWord && wordIdx == IDX_W'(k)) tileBuf[k] <= memData;
      end
    end
    for (genvar p = 0; p < PAL_DEPTH; p++) begin : g_pal
      always_ff @(posedge clk) begin
        if (!rstN) palMem[p] <= '0;
        else if (palWe && palIdx == 4'(p)) palMem[p] <= palData;
      end
    end
  endgenerate

  always_comb begin
    for (int k = 0; k < WORDS - 1; k++) tileBits[k*WORD_W +: WORD_W] = tileBuf[k];
    tileBits[(WORDS-1)*WORD_W +: WORD_W] = memData;
  end

  assign code = tileBits[int'(subIdx)*CODE_W +: CODE_W];

  always_ff @(posedge clk) begin
    if (!rstN) colorReg <= '0;
    else if (strobe.finishTile) colorReg <= palMem[code];
  end

  assign rspColor = colorReg;
endmodule

// File: rtl/texel_tile_fetch.sv
module texel_tile_fetch
  import texel_fetch_pkg::*;
#(
  parameter int U_W        = 8,
  parameter int V_W        = 8,
  parameter int ADDR_W     = 20,
  parameter int COLOR_W    = 8,
  parameter int FIRST_WAIT = 7,
  parameter int NEXT_WAIT  = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [U_W-1:0]     reqU,
  input  logic [V_W-1:0]     reqV,
  input  logic [ADDR_W-1:0]  texBase,
  output logic               rspValid,
  input  logic               rspReady,
  output logic [COLOR_W-1:0] rspColor,
  input  logic               palWe,
  input  logic [3:0]         palIdx,
  input  logic [COLOR_W-1:0] palData,
  output logic [ADDR_W-1:0]  memAddr,
  output logic               memRd,
  input  logic [15:0]        memData
);
  ctrlStrobe_t strobe;
  logic lastWord;

  tf_ctrl #(.FIRST_WAIT(FIRST_WAIT), .NEXT_WAIT(NEXT_WAIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .rspReady(rspReady),
    .lastWord(lastWord), .strobe(strobe), .reqReady(reqReady),
    .rspValid(rspValid), .memRd(memRd)
  );

  tf_datapath #(.U_W(U_W), .V_W(V_W), .ADDR_W(ADDR_W), .COLOR_W(COLOR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqU(reqU), .reqV(reqV),
    .texBase(texBase), .palWe(palWe), .palIdx(palIdx), .palData(palData),
    .memData(memData), .memAddr(memAddr), .lastWord(lastWord), .rspColor(rspColor)
  );
endmodule

// File: rtl/texel_tile_fetch_chk.sv
module texel_tile_fetch_chk #(
  parameter int ADDR_W  = 20,
  parameter int COLOR_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic               reqReady,
  input logic               rspValid,
  input logic               rspReady,
  input logic [COLOR_W-1:0] rspColor,
  input logic               memRd,
  input logic [ADDR_W-1:0]  memAddr
);
  p_hold_rsp_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> (rspValid && $stable(rspColor)));

  p_one_outstanding_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  p_burst_starts_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> memRd);

  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && $past(memRd)) |-> (memAddr == $past(memAddr) ||
                                 memAddr == $past(memAddr) + ADDR_W'(1)));

  p_rsp_after_burst_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rspValid) |-> $past(memRd));

  p_ready_returns_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspReady) |=> reqReady);
endmodule

bind texel_tile_fetch texel_tile_fetch_chk #(.ADDR_W(ADDR_W), .COLOR_W(COLOR_W)) u_chk (.*);

// File: tb/sim_texel_tile_fetch.sv
module sim_texel_tile_fetch;
  localparam int U_W = 8, V_W = 8, ADDR_W = 20, COLOR_W = 8;
  localparam int FW = 7, NW = 3;
  localparam int TILES_PER_ROW = 1 << (U_W - 2);

  logic clk = 0, rstN = 0;
  logic reqValid = 0, rspReady = 0, palWe = 0;
  logic [U_W-1:0] reqU = '0;
  logic [V_W-1:0] reqV = '0;
  logic [ADDR_W-1:0] texBase = '0;
  logic [3:0] palIdx = '0;
  logic [COLOR_W-1:0] palData = '0;
  logic reqReady, rspValid, memRd;
  logic [COLOR_W-1:0] rspColor;
  logic [ADDR_W-1:0] memAddr;
  logic [15:0] memData;

  int nChecks = 0, nFail = 0, cycles = 0;
  bit done = 0;
  logic [COLOR_W-1:0] benchPal [16];

  always #5 clk = ~clk;

  function automatic logic [15:0] memWord(input logic [ADDR_W-1:0] a);
    logic [15:0] t;
    t = a[15:0] * 16'h9E37;
    return t ^ {a[19:16], a[11:0]};
  endfunction

  assign memData = memRd ? memWord(memAddr) : 16'h0000;

  texel_tile_fetch u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqU(reqU), .reqV(reqV), .texBase(texBase), .rspValid(rspValid),
    .rspReady(rspReady), .rspColor(rspColor), .palWe(palWe), .palIdx(palIdx),
    .palData(palData), .memAddr(memAddr), .memRd(memRd), .memData(memData)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference model, updated each rising edge
  int mState = 0, mWord = 0, mWait = 0, mSub = 0;
  logic [ADDR_W-1:0] mAddr = '0;
  logic [15:0] mTile [4];
  logic [COLOR_W-1:0] mColor = '0;
  logic [COLOR_W-1:0] mPal [16];

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mWord = 0; mWait = 0; mColor = '0;
      for (int i = 0; i < 16; i++) mPal[i] = '0;
    end else begin
      case (mState)
        0: if (reqValid) begin
          mState = 1; mWord = 0; mWait = FW;
          mAddr = texBase + ADDR_W'(((int'(reqV) / 4) * TILES_PER_ROW + int'(reqU) / 4) * 4);
          mSub = (int'(reqV) % 4) * 4 + int'(reqU) % 4;
        end
        1: begin
          if (mWait == 1) begin
            mTile[mWord] = memWord(mAddr + ADDR_W'(mWord));
            if (mWord == 3) begin
              mColor = mPal[(mTile[mSub / 4] >> ((mSub % 4) * 4)) & 16'hF];
              mState = 2;
            end else begin
              mWord++; mWait = NW;
            end
          end else mWait--;
        end
        default: if (rspReady) mState = 0;
      endcase
      if (palWe) mPal[palIdx] = palData;
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      check(reqReady == (mState == 0), "R6", "reqReady", reqReady, mState == 0);
      check(rspValid == (mState == 2), "R8", "rspValid", rspValid, mState == 2);
      check(memRd == (mState == 1), "R3", "memRd", memRd, mState == 1);
      if (mState == 1)
        check(memAddr == mAddr + ADDR_W'(mWord), mWord == 0 ? "R2" : "R3", "memAddr",
              memAddr, mAddr + ADDR_W'(mWord));
      if (mState == 2)
        check(rspColor == mColor, "R5", "rspColor", rspColor, mColor);
    end
  end

  function automatic logic [COLOR_W-1:0] expColor(input int u, input int v,
                                                  input logic [ADDR_W-1:0] base);
    logic [ADDR_W-1:0] a;
    int sub;
    logic [15:0] w;
    a = base + ADDR_W'(((v / 4) * TILES_PER_ROW + u / 4) * 4);
    sub = (v % 4) * 4 + u % 4;
    w = memWord(a + ADDR_W'(sub / 4));
    return benchPal[(w >> ((sub % 4) * 4)) & 16'hF];
  endfunction

  function automatic int expCode(input int u, input int v, input logic [ADDR_W-1:0] base);
    logic [ADDR_W-1:0] a;
    int sub;
    logic [15:0] w;
    a = base + ADDR_W'(((v / 4) * TILES_PER_ROW + u / 4) * 4);
    sub = (v % 4) * 4 + u % 4;
    w = memWord(a + ADDR_W'(sub / 4));
    return int'((w >> ((sub % 4) * 4)) & 16'hF);
  endfunction

  task automatic writePal(input int idx, input logic [COLOR_W-1:0] val);
    @(negedge clk);
    palWe = 1; palIdx = 4'(idx); palData = val;
    benchPal[idx] = val;
    @(negedge clk);
    palWe = 0;
  endtask

  task automatic fetch(input int u, input int v, input logic [ADDR_W-1:0] base,
                       input int stall, output logic [COLOR_W-1:0] col, output int lat);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1; reqU = U_W'(u); reqV = V_W'(v); texBase = base;
    @(negedge clk);
    reqValid = 0;
    lat = 1;
    while (!rspValid) begin @(negedge clk); lat++; end
    col = rspColor;
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      check(rspValid == 1 && rspColor == col, "R7", "held response", rspColor, col);
    end
    rspReady = 1;
    @(negedge clk);
    rspReady = 0;
    check(reqReady == 1, "R10", "ready after handshake", reqReady, 1);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        nFail++; nChecks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
        $finish;
      end
    end
  end

  initial begin
    logic [COLOR_W-1:0] c;
    int lat;
    int code;
    for (int i = 0; i < 16; i++) benchPal[i] = '0;
    repeat (3) @(negedge clk);
    check(reqReady == 1 && rspValid == 0 && memRd == 0, "R1", "reset outputs",
          {reqReady, rspValid, memRd}, 3'b100);
    rstN = 1;

    // R1: palette cleared by reset
    fetch(5, 9, 20'h01000, 0, c, lat);
    check(c == 0, "R1", "palette reset colour", c, 0);
    check(lat == FW + 3 * NW + 1, "R8", "latency", lat, FW + 3 * NW + 1);

    for (int i = 0; i < 16; i++) writePal(i, COLOR_W'((i * 37) ^ 8'hA5));

    // R4/R5: texels across tile corners and address extremes
    begin
      int us[8] = '{0, 3, 0, 255, 6, 129, 77, 250};
      int vs[8] = '{0, 0, 3, 255, 1, 2, 200, 13};
      logic [ADDR_W-1:0] bs[8] = '{20'h00000, 20'h00040, 20'h12345, 20'hFFFF0,
                                   20'h00800, 20'h3A000, 20'h7FFFC, 20'h00001};
      for (int t = 0; t < 8; t++) begin
        fetch(us[t], vs[t], bs[t], 0, c, lat);
        check(c == expColor(us[t], vs[t], bs[t]), "R4", "texel colour", c,
              expColor(us[t], vs[t], bs[t]));
      end
    end

    // R7: consumer stalls
    fetch(42, 17, 20'h05550, 6, c, lat);
    check(c == expColor(42, 17, 20'h05550), "R7", "stalled colour", c,
          expColor(42, 17, 20'h05550));

    // R9: palette rewritten mid-fetch
    code = expCode(100, 60, 20'h0ABC0);
    fork
      fetch(100, 60, 20'h0ABC0, 0, c, lat);
      begin repeat (6) @(negedge clk); writePal(code, 8'h3C); end
    join
    check(c == 8'h3C, "R9", "mid-fetch palette write", c, 8'h3C);

    // R10: back-to-back requests
    for (int t = 0; t < 4; t++) begin
      fetch(t * 61, t * 29, 20'h20000, 0, c, lat);
      check(c == expColor(t * 61, t * 29, 20'h20000), "R5", "b2b colour", c,
            expColor(t * 61, t * 29, 20'h20000));
    end

    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule